// File: doc/BRIEF.md
# Per-CPU Masked Interrupt Fan-In

This block gathers a parameterised number of 32-bit words of level-sensitive interrupt sources. It drives one interrupt line per CPU toward that CPU's parent controller. Every CPU owns a private bank of mask words. A source reaches a CPU's line only while the source is high and the CPU's mask bit for it is low. The same source can therefore be enabled for one CPU and blocked for another.

Software reaches each bank through a plain 32-bit register port. A bank holds four groups of registers, placed back to back:

- a live view of the source levels;
- a readback of the mask;
- a write-one-to-set mask register;
- a write-one-to-clear mask register.

The set and clear registers let software change single mask bits without a read-modify-write sequence. The size of each group follows the word-count parameter, and so does the offset of every group after the first.

Top module: `irqfan_top`

## Requirements
- R1: Reset sets every mask bit in every bank to 1. It also drives every `irqOut` bit to 0 and `regRdata` to 0.
- R2: Source n is bit n%32 of word n/32 of `srcLevel`. A STATUS read (group 0) returns the live source word. Writes to STATUS change nothing.
- R3: The bank for CPU c starts at byte c*S, where S = 2^ceil(log2(16*NUM_WORDS)). Inside a bank, word w of group g sits at byte (g*NUM_WORDS + w)*4. The groups are g=0 STATUS, g=1 MASK_STATUS, g=2 MASK_SET and g=3 MASK_CLEAR. Address bits [1:0] are ignored.
- R4: A write to MASK_SET sets each mask bit whose write-data bit is 1. Mask bits written as 0 keep their value.
- R5: A write to MASK_CLEAR clears each mask bit whose write-data bit is 1. Mask bits written as 0 keep their value.
- R6: A MASK_STATUS read returns that CPU's current mask word. Writes to MASK_STATUS change nothing.
- R7: Reads of MASK_SET or MASK_CLEAR addresses return 0.
- R8: An address out of range reads as 0, and a write to it changes no mask. An address is out of range when its CPU field is NUM_CPUS or more, or when its in-bank word index is 4*NUM_WORDS or more.
- R9: `irqOut[c]` is registered. It is 1 in the cycle after a cycle in which some source is high while CPU c's mask bit for that source is 0. Otherwise it is 0 in that next cycle.
- R10: A mask write acts only on the addressed CPU's bank. The other banks and their `irqOut` bits are unaffected.
- R11: `regRdata` is registered. It takes the addressed value on a clock edge where `regRead` is 1 and holds its value otherwise. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcLevel | input | NUM_WORDS*32 | Level-sensitive interrupt sources |
| regRead | input | 1 | Read request for the register port |
| regWrite | input | 1 | Write request for the register port |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| irqOut | output | NUM_CPUS | One interrupt line per CPU |

## Verification
The assertions check the following on every cycle:

- a set write leaves the written bits at 1, and a clear write leaves them at 0;
- a bank that no write selects keeps its mask unchanged;
- each CPU line follows the pending term of the previous cycle;
- reads of the set and clear registers, and reads of out-of-range addresses, return zero.

The bench scenarios show the rest:

- the address arithmetic that picks a group and a word;
- that writes to STATUS and MASK_STATUS are ignored;
- that the all-ones mask after reset holds;
- that a source steered to one CPU stays silent on the other.

A behavioural model runs alongside the scenarios and compares both outputs on every clock during directed and random traffic.

// File: rtl/irqfan_pkg.sv
package irqfan_pkg;

  localparam int WORD_BITS   = 32;
  localparam int MAX_WORDS   = 8;
  localparam int CPU_FIELD_W = 8;
  localparam int WORD_IDX_W  = $clog2(MAX_WORDS);

  typedef enum logic [1:0] {
    GRP_LIVE     = 2'd0,
    GRP_MASKVIEW = 2'd1,
    GRP_MASKSET  = 2'd2,
    GRP_MASKCLR  = 2'd3
  } grp_e;

  typedef struct packed {
    logic                   hit;
    logic                   doRead;
    logic                   doSet;
    logic                   doClr;
    grp_e                   grp;
    logic [WORD_IDX_W-1:0]  wordIdx;
    logic [CPU_FIELD_W-1:0] cpuIdx;
  } strobe_t;

endpackage

// File: rtl/irqfan_ctrl.sv
module irqfan_ctrl
  import irqfan_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 12
) (
  input  logic              regRead,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb
);

  localparam int BANK_BYTES = NUM_WORDS * 16;
  localparam int BANK_AW    = $clog2(BANK_BYTES);
  localparam int CPU_W      = ADDR_W - BANK_AW;
  localparam int REG_CNT    = 4 * NUM_WORDS;

  logic [CPU_W-1:0]   cpuField;
  logic [BANK_AW-3:0] regField;
  logic [1:0]         unusedByteLane;
  logic [31:0]        cpuNum;
  logic [31:0]        regNum;
  logic               inRange;

  assign cpuField       = regAddr[ADDR_W-1:BANK_AW];
  assign regField       = regAddr[BANK_AW-1:2];
  assign unusedByteLane = regAddr[1:0];
  assign cpuNum         = 32'(cpuField);
  assign regNum         = 32'(regField);
  assign inRange        = (cpuNum < 32'(NUM_CPUS)) && (regNum < 32'(REG_CNT));

  always_comb begin
    strb         = '0;
    strb.hit     = inRange;
    strb.doRead  = regRead;
    strb.grp     = grp_e'(2'(regNum / 32'(NUM_WORDS)));
    strb.wordIdx = WORD_IDX_W'(regNum % 32'(NUM_WORDS));
    strb.cpuIdx  = CPU_FIELD_W'(cpuNum);
    strb.doSet   = inRange && regWrite && (strb.grp == GRP_MASKSET);
    strb.doClr   = inRange && regWrite && (strb.grp == GRP_MASKCLR);
  end

endmodule

// File: rtl/irqfan_datapath.sv
module irqfan_datapath
  import irqfan_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_WORDS*WORD_BITS-1:0] srcLevel,
  input  logic [WORD_BITS-1:0]           regWdata,
  input  strobe_t                        strb,
  output logic [WORD_BITS-1:0]           regRdata,
  output logic [NUM_CPUS-1:0]            irqOut
);

  localparam int SRC_W = NUM_WORDS * WORD_BITS;

  logic [SRC_W-1:0]     maskArr [NUM_CPUS];
  logic [NUM_CPUS-1:0]  irqReg;
  logic [WORD_BITS-1:0] rdReg;
  logic [WORD_BITS-1:0] rdNext;
  logic [WORD_BITS-1:0] liveWord;
  logic [WORD_BITS-1:0] maskWord;

  // Mask banks: write-one-to-set and write-one-to-clear per word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CPUS; c++) maskArr[c] <= '1;
    end else begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (strb.cpuIdx == CPU_FIELD_W'(c) && strb.wordIdx == WORD_IDX_W'(w)) begin
            if (strb.doSet)
              maskArr[c][w*WORD_BITS +: WORD_BITS] <=
                maskArr[c][w*WORD_BITS +: WORD_BITS] | regWdata;
            else if (strb.doClr)
              maskArr[c][w*WORD_BITS +: WORD_BITS] <=
                maskArr[c][w*WORD_BITS +: WORD_BITS] & ~regWdata;
          end
        end
      end
    end
  end

  // Registered per-CPU interrupt lines.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReg <= '0;
    end else begin
      for (int c = 0; c < NUM_CPUS; c++) irqReg[c] <= |(srcLevel & ~maskArr[c]);
    end
  end

  // Read selection.
  always_comb begin
    liveWord = '0;
    maskWord = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (strb.wordIdx == WORD_IDX_W'(w)) begin
        liveWord = srcLevel[w*WORD_BITS +: WORD_BITS];
        for (int c = 0; c < NUM_CPUS; c++)
          if (strb.cpuIdx == CPU_FIELD_W'(c)) maskWord = maskArr[c][w*WORD_BITS +: WORD_BITS];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.hit) begin
      unique case (strb.grp)
        GRP_LIVE:     rdNext = liveWord;
        GRP_MASKVIEW: rdNext = maskWord;
        default:      rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdReg <= '0;
    else if (strb.doRead) rdReg <= rdNext;
  end

  assign regRdata = rdReg;
  assign irqOut   = irqReg;

  // Read-port checks.
  assert_rd_wo_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doRead && strb.hit && (strb.grp == GRP_MASKSET || strb.grp == GRP_MASKCLR))
      |=> (regRdata == '0));

  assert_rd_outrange_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doRead && !strb.hit) |=> (regRdata == '0));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doRead |=> $stable(regRdata));

  // Per-CPU bank and line checks.
  for (genvar gc = 0; gc < NUM_CPUS; gc++) begin : g_chk
    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
      !((strb.doSet || strb.doClr) && strb.cpuIdx == CPU_FIELD_W'(gc))
        |=> $stable(maskArr[gc]));

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
      (|(srcLevel & ~maskArr[gc])) |=> irqOut[gc]);

    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
      !(|(srcLevel & ~maskArr[gc])) |=> !irqOut[gc]);

    for (genvar gw = 0; gw < NUM_WORDS; gw++) begin : g_word
      assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
        (strb.doSet && strb.cpuIdx == CPU_FIELD_W'(gc) && strb.wordIdx == WORD_IDX_W'(gw))
          |=> ((maskArr[gc][gw*WORD_BITS +: WORD_BITS] & $past(regWdata)) == $past(regWdata)));

      assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
        (strb.doClr && strb.cpuIdx == CPU_FIELD_W'(gc) && strb.wordIdx == WORD_IDX_W'(gw))
          |=> ((maskArr[gc][gw*WORD_BITS +: WORD_BITS] & $past(regWdata)) == '0));
    end
  end

endmodule

// File: rtl/irqfan_top.sv
module irqfan_top
  import irqfan_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_WORDS*WORD_BITS-1:0] srcLevel,
  input  logic                           regRead,
  input  logic                           regWrite,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [WORD_BITS-1:0]           regWdata,
  output logic [WORD_BITS-1:0]           regRdata,
  output logic [NUM_CPUS-1:0]            irqOut
);

  strobe_t strb;

  irqfan_ctrl #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .regRead (regRead),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irqfan_datapath #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_WORDS(NUM_WORDS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcLevel(srcLevel),
    .regWdata(regWdata),
    .strb    (strb),
    .regRdata(regRdata),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/irqfan_top_bench.sv
module irqfan_top_bench;

  localparam int NC   = 2;
  localparam int NW   = 2;
  localparam int AW   = 12;
  localparam int SPAN = 1 << $clog2(16 * NW);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NW*32-1:0]  srcLevel = '0;
  logic              regRead = 1'b0;
  logic              regWrite = 1'b0;
  logic [AW-1:0]     regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic [NC-1:0]     irqOut;

  int total = 0;
  int bad   = 0;
  string curTag = "R1";

  // Behavioural reference state.
  logic [31:0]   mMask [NC][NW];
  logic [NC-1:0] expIrq;
  logic [31:0]   expRd;

  always #10 clk = ~clk;

  irqfan_top #(.NUM_CPUS(NC), .NUM_WORDS(NW), .ADDR_W(AW)) u_irqfan_top (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .regRead(regRead),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic logic [AW-1:0] addrOf(input int c, input int g, input int w);
    return AW'(c * SPAN + (g * NW + w) * 4);
  endfunction

  function automatic bit decode(input logic [AW-1:0] a, output int c, output int g, output int w);
    int r;
    c = int'(a) / SPAN;
    r = (int'(a) % SPAN) / 4;
    g = r / NW;
    w = r % NW;
    return (c < NC) && (r < 4 * NW);
  endfunction

  function automatic logic [31:0] modelRead(input logic [AW-1:0] a);
    int c, g, w;
    if (!decode(a, c, g, w)) return 32'h0;
    if (g == 0) return srcLevel[w*32 +: 32];
    if (g == 1) return mMask[c][w];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NC; c++)
        for (int w = 0; w < NW; w++) mMask[c][w] <= 32'hFFFF_FFFF;
      expIrq <= '0;
      expRd  <= '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        logic any;
        any = 1'b0;
        for (int w = 0; w < NW; w++)
          if ((srcLevel[w*32 +: 32] & ~mMask[c][w]) != 0) any = 1'b1;
        expIrq[c] <= any;
      end
      if (regRead) expRd <= modelRead(regAddr);
      if (regWrite) begin
        int c, g, w;
        if (decode(regAddr, c, g, w)) begin
          if (g == 2) mMask[c][w] <= mMask[c][w] | regWdata;
          if (g == 3) mMask[c][w] <= mMask[c][w] & ~regWdata;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock; compare against the model away from the edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (rstN) begin
      check("R9/R10 irqOut", 32'(irqOut), 32'(expIrq));
      check(curTag, regRdata, expRd);
    end
  endtask

  task automatic access(input bit rd, input bit wr, input logic [AW-1:0] a, input logic [31:0] d);
    regRead  = rd;
    regWrite = wr;
    regAddr  = a;
    regWdata = d;
    step();
    regRead  = 1'b0;
    regWrite = 1'b0;
  endtask

  task automatic readExpect(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    curTag = tag;
    access(1'b1, 1'b0, a, 32'h0);
    check(tag, regRdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 irq after reset", 32'(irqOut), 32'h0);
    check("R1 rdata after reset", regRdata, 32'h0);

    // R1: masks start all ones
    readExpect("R1", addrOf(0, 1, 0), 32'hFFFF_FFFF);
    readExpect("R1", addrOf(1, 1, 1), 32'hFFFF_FFFF);
    step();
    check("R1 irq masked", 32'(irqOut), 32'h0);

    // R2: live status view, source 37 = word1 bit5
    srcLevel = {32'h0000_0020, 32'hA5A5_0000};
    readExpect("R2", addrOf(0, 0, 1), 32'h0000_0020);
    readExpect("R2", addrOf(1, 0, 0), 32'hA5A5_0000);
    curTag = "R2";
    access(1'b0, 1'b1, addrOf(0, 0, 0), 32'h0);
    readExpect("R2 status write ignored", addrOf(0, 0, 0), 32'hA5A5_0000);

    // R5 / R4: clear then set
    curTag = "R5";
    access(1'b0, 1'b1, addrOf(0, 3, 0), 32'h0000_FFFF);
    readExpect("R5", addrOf(0, 1, 0), 32'hFFFF_0000);
    curTag = "R4";
    access(1'b0, 1'b1, addrOf(0, 2, 0), 32'h0000_00F0);
    readExpect("R4", addrOf(0, 1, 0), 32'hFFFF_00F0);

    // R6: writes to the mask view are ignored
    curTag = "R6";
    access(1'b0, 1'b1, addrOf(0, 1, 0), 32'h0);
    readExpect("R6", addrOf(0, 1, 0), 32'hFFFF_00F0);

    // R7: set/clear registers read as zero
    readExpect("R7", addrOf(0, 2, 0), 32'h0);
    readExpect("R7", addrOf(1, 3, 1), 32'h0);

    // R9: steer source 37 to CPU0 only
    curTag = "R9";
    access(1'b0, 1'b1, addrOf(0, 2, 0), 32'hFFFF_FFFF);
    srcLevel = '0;
    access(1'b0, 1'b1, addrOf(0, 3, 1), 32'h0000_0020);
    srcLevel[37] = 1'b1;
    step();
    step();
    check("R9 rise cpu0 only", 32'(irqOut), 32'h1);
    srcLevel[37] = 1'b0;
    step();
    step();
    check("R9 fall", 32'(irqOut), 32'h0);

    // R10: move the source to CPU1
    curTag = "R10";
    access(1'b0, 1'b1, addrOf(1, 3, 1), 32'h0000_0020);
    access(1'b0, 1'b1, addrOf(0, 2, 1), 32'h0000_0020);
    srcLevel[37] = 1'b1;
    step();
    step();
    check("R10 cpu1 only", 32'(irqOut), 32'h2);
    readExpect("R10 cpu0 word0 untouched", addrOf(0, 1, 0), 32'hFFFF_FFFF);

    // R8: out of range accesses
    curTag = "R8";
    access(1'b0, 1'b1, AW'(NC * SPAN + 12), 32'hFFFF_FFFF);
    access(1'b0, 1'b1, AW'(12'hFFC), 32'hFFFF_FFFF);
    readExpect("R8", AW'(NC * SPAN + 4), 32'h0);
    readExpect("R8 mask intact", addrOf(1, 1, 1), 32'hFFFF_FFDF);

    // R11: read data holds while idle, read-before-write
    step();
    step();
    check("R11 hold", regRdata, 32'hFFFF_FFDF);
    curTag = "R11";
    access(1'b1, 1'b1, addrOf(1, 1, 1), 32'h0);
    check("R11 read during write", regRdata, 32'hFFFF_FFDF);

    // R3: sweep every register in every bank
    curTag = "R3";
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < 4 * NW; r++)
        access(1'b1, 1'b0, AW'(c * SPAN + r * 4), 32'h0);

    // Random traffic against the model
    curTag = "R3 random";
    for (int i = 0; i < 3000; i++) begin
      if ((i % 7) == 0) srcLevel = {$urandom, $urandom};
      access(1'($urandom), 1'($urandom),
             ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % ((NC + 1) * SPAN)),
             $urandom);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule